// File: doc/BRIEF.md
# Codec Immediate Command Port

This block is a small register-mapped slave that lets software send one command word to an audio codec and collect the 32-bit answer without any DMA machinery. Software loads a command word, then writes the status register with its start and valid bits both set. The block presents the word on a valid/ready request port, waits for the codec's response pulse, stores the response, and raises a sticky valid flag while dropping busy on the same clock.

A command has finished successfully when the status register reads valid set and busy clear together. The valid flag stays set until software writes a one to it. A controller run bit, with readback, holds the codec link in reset while it is zero. In that state the status flags and the codec-presence field read as zero, and any pending command is abandoned. The presence field reports which codec slots are populated.

Register reads are combinational from the address. Writes take effect on the rising clock edge where `reg_wr` is high. The serial link framing lives elsewhere.

Top module: `codec_imm_cmd`

## Requirements
- R1: After `rst_n` is released, the run register (byte 0x08) reads 0, status (0x68) reads 0, command (0x60) reads 0, response (0x64) reads 0, and `link_rst_n` is 0.
- R2: Writing byte 0x08 with bit 0 = 0 puts the controller in reset and writing bit 0 = 1 takes it out. The register reads back the written bit, and `link_rst_n` equals it.
- R3: The word at 0x0C carries `codec_present` in bits [16+SLOTS-1:16], which is byte 0x0E. It reads `codec_present` while out of reset and 0 while in reset. All other bits read 0.
- R4: The command register at 0x60 is read/write and drives `cmd_word`. A write to it while busy is ignored.
- R5: A status write with bit 0 = 1, made while out of reset and not busy, sets busy (status bit 0) and clears valid (bit 1). On the next cycle it raises `cmd_valid`, which holds with a stable `cmd_word` until `cmd_ready` is seen.
- R6: After the request handshake, the first cycle with `resp_valid` high latches `resp_data` into 0x64, sets valid and clears busy on the same edge, so status reads 2'b10.
- R7: A start write while busy is ignored. No second request is issued, busy stays set, and the eventual response belongs to the first command.
- R8: Writing 1 to status bit 1 clears valid. Writing 0 to it leaves valid unchanged.
- R9: If a valid-clear write lands on the same edge as a completion, the completion wins and valid reads 1.
- R10: While in reset, busy, valid and `cmd_valid` are held at 0 and start writes are ignored. Entering reset mid-command abandons that command.
- R11: `resp_valid` outside the response-wait phase, whether idle or before the request is accepted, does not change the response register or the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW | Byte address of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| codec_present | input | SLOTS | One bit per populated codec slot |
| link_rst_n | output | 1 | Codec link reset, low while the controller is in reset |
| cmd_valid | output | 1 | Command word offered to the codec |
| cmd_ready | input | 1 | Codec accepts the command word |
| cmd_word | output | 32 | Command word |
| resp_valid | input | 1 | One-cycle response pulse from the codec |
| resp_data | input | 32 | Response word |

## Verification
The delicate coincidence is a software write that clears the valid flag landing on the same edge as the hardware completion that sets it. The bench switches its codec model to manual drive so that the response pulse and the clearing write can be placed in the very same cycle. It then expects status 2'b10 and the new response word. A second overlap, a start write arriving while a command is still outstanding, is provoked by holding the request unaccepted. It is judged by counting request handshakes and by which response is finally stored.

// File: rtl/codec_imm_cmd.sv
module codec_imm_cmd #(
  parameter int SLOTS = 3,
  parameter int AW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [AW-1:0]    reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic [SLOTS-1:0] codec_present,
  output logic             link_rst_n,
  output logic             cmd_valid,
  input  logic             cmd_ready,
  output logic [31:0]      cmd_word,
  input  logic             resp_valid,
  input  logic [31:0]      resp_data
);
  localparam logic [AW-1:0] A_RUN  = AW'(8'h08);
  localparam logic [AW-1:0] A_PRES = AW'(8'h0C);
  localparam logic [AW-1:0] A_CMD  = AW'(8'h60);
  localparam logic [AW-1:0] A_RESP = AW'(8'h64);
  localparam logic [AW-1:0] A_STAT = AW'(8'h68);
  localparam int PRES_LSB = 16;

  logic        run_q, busy_q, sent_q, valid_q;
  logic [31:0] cmd_q, resp_q;

  wire wr_run  = reg_wr && reg_addr == A_RUN;
  wire wr_cmd  = reg_wr && reg_addr == A_CMD;
  wire wr_stat = reg_wr && reg_addr == A_STAT;
  wire run_nx  = wr_run ? reg_wdata[0] : run_q;
  wire start   = wr_stat && reg_wdata[0] && run_q && !busy_q;
  wire done    = busy_q && sent_q && resp_valid;

  assign cmd_valid  = busy_q && !sent_q;
  assign cmd_word   = cmd_q;
  assign link_rst_n = run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      busy_q  <= 1'b0;
      sent_q  <= 1'b0;
      valid_q <= 1'b0;
      cmd_q   <= '0;
      resp_q  <= '0;
    end else begin
      run_q <= run_nx;
      if (wr_cmd && !busy_q) cmd_q <= reg_wdata;
      if (!run_nx) begin
        busy_q  <= 1'b0;
        sent_q  <= 1'b0;
        valid_q <= 1'b0;
      end else if (start) begin
        busy_q  <= 1'b1;
        sent_q  <= 1'b0;
        valid_q <= 1'b0;
      end else if (done) begin
        busy_q  <= 1'b0;
        sent_q  <= 1'b0;
        valid_q <= 1'b1;
        resp_q  <= resp_data;
      end else begin
        if (cmd_valid && cmd_ready) sent_q <= 1'b1;
        if (wr_stat && reg_wdata[1]) valid_q <= 1'b0;
      end
    end
  end

  logic [31:0] pres_word;
  always_comb begin
    pres_word = '0;
    if (run_q) pres_word[PRES_LSB +: SLOTS] = codec_present;
  end

  always_comb begin
    case (reg_addr)
      A_RUN:   reg_rdata = {31'd0, run_q};
      A_PRES:  reg_rdata = pres_word;
      A_CMD:   reg_rdata = cmd_q;
      A_RESP:  reg_rdata = resp_q;
      A_STAT:  reg_rdata = {30'd0, valid_q, busy_q};
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/codec_imm_cmd_chk.sv
module codec_imm_cmd_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic [AW-1:0] reg_addr,
  input logic [31:0]   reg_wdata,
  input logic          run,
  input logic          busy,
  input logic          valid,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic [31:0]   cmd_word,
  input logic          resp_valid,
  input logic [31:0]   resp_data,
  input logic [31:0]   resp_q
);
  wire run_wr  = reg_wr && reg_addr == AW'(8'h08);
  wire stat_wr = reg_wr && reg_addr == AW'(8'h68);

  AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    run && !busy && stat_wr && reg_wdata[0] |=> busy && !valid); // R5
  AST_CMD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready && !run_wr |=> cmd_valid && $stable(cmd_word)); // R5
  AST_DONE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    run && busy && !cmd_valid && resp_valid && !run_wr |=> !busy && valid && resp_q == $past(resp_data)); // R6
  AST_BUSY_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    run && busy && !resp_valid && !run_wr |=> busy); // R7
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !busy && !valid && !cmd_valid); // R10
  AST_IDLE_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(resp_q)); // R11
endmodule

bind codec_imm_cmd codec_imm_cmd_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .run(run_q), .busy(busy_q), .valid(valid_q),
  .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_word(cmd_word),
  .resp_valid(resp_valid), .resp_data(resp_data), .resp_q(resp_q)
);

// File: tb/codec_imm_cmd_tb_top.sv
`timescale 1ns/1ps
module codec_imm_cmd_tb_top;
  localparam int SLOTS = 3;
  localparam int AW = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, reg_wr = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [SLOTS-1:0] codec_present = 3'b101;
  logic link_rst_n, cmd_valid, cmd_ready, resp_valid;
  logic [31:0] cmd_word, resp_data;

  logic auto_mode = 1'b1, hold_ready = 1'b0;
  logic a_ready = 1'b0, a_rv = 1'b0, m_ready = 1'b0, m_rv = 1'b0;
  logic [31:0] a_rd = '0, m_rd = '0;
  assign cmd_ready  = auto_mode ? a_ready : m_ready;
  assign resp_valid = auto_mode ? a_rv : m_rv;
  assign resp_data  = auto_mode ? a_rd : m_rd;

  int n_cmp = 0, n_bad = 0, hs_count = 0;

  codec_imm_cmd #(.SLOTS(SLOTS), .AW(AW)) dut_i (.*);

  function automatic logic [31:0] resp_of(logic [31:0] w);
    return {w[15:0], w[31:16]} ^ 32'h5A3C_C3A5;
  endfunction

  logic        pend = 1'b0;
  int          dly = 0;
  logic [31:0] seen_word = '0;
  always @(negedge clk) begin
    if (auto_mode) begin
      a_rv = 1'b0;
      if (pend) begin
        if (dly == 0) begin a_rv = 1'b1; a_rd = resp_of(seen_word); pend = 1'b0; end
        else dly = dly - 1;
      end
      a_ready = !hold_ready && ($urandom % 3 != 0);
      if (cmd_valid && a_ready) begin
        pend = 1'b1; seen_word = cmd_word; dly = $urandom_range(0, 6);
        hs_count = hs_count + 1;
      end
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic wait_done();
    logic [31:0] s;
    for (int i = 0; i < 300; i++) begin
      rd(8'h68, s);
      if (s[1:0] == 2'b10) break;
      @(negedge clk);
    end
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog R6 actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d, w, b;
    int hs0;
    void'($urandom(32'd7731));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(8'h08, d); chk("R1 run", d, 0);
    rd(8'h68, d); chk("R1 status", d, 0);
    rd(8'h60, d); chk("R1 cmd", d, 0);
    rd(8'h64, d); chk("R1 resp", d, 0);
    chk("R1 link_rst_n", {31'd0, link_rst_n}, 0);
    rd(8'h0C, d); chk("R3 presence in reset", d, 0);

    wr(8'h60, 32'h1234_5678);
    wr(8'h68, 32'h3);
    rd(8'h68, d); chk("R10 start in reset", d, 0);
    chk("R10 cmd_valid in reset", {31'd0, cmd_valid}, 0);

    wr(8'h08, 32'h1);
    rd(8'h08, d); chk("R2 run readback", d, 1);
    chk("R2 link_rst_n", {31'd0, link_rst_n}, 1);
    rd(8'h0C, d); chk("R3 presence", d, 32'h5 << 16);

    for (int k = 0; k < 40; k++) begin
      w = $urandom;
      wr(8'h60, w);
      chk("R4 cmd_word", cmd_word, w);
      wr(8'h68, 32'h3);
      wait_done();
      rd(8'h68, d); chk("R6 status done", d, 2);
      rd(8'h64, d); chk("R6 response", d, resp_of(w));
    end

    hold_ready = 1'b1;
    w = 32'hCAFE_0001; b = 32'hBEEF_0002;
    wr(8'h60, w);
    wr(8'h68, 32'h3);
    rd(8'h68, d); chk("R5 busy set valid cleared", d, 1);
    chk("R5 cmd_valid", {31'd0, cmd_valid}, 1);
    wr(8'h60, b);
    chk("R4 cmd write ignored while busy", cmd_word, w);
    hs0 = hs_count;
    wr(8'h68, 32'h3);
    rd(8'h68, d); chk("R7 still busy", d, 1);
    hold_ready = 1'b0;
    wait_done();
    repeat (10) @(negedge clk);
    chk("R7 one handshake", hs_count, hs0 + 1);
    rd(8'h64, d); chk("R7 first response kept", d, resp_of(w));

    wr(8'h68, 32'h0);
    rd(8'h68, d); chk("R8 write zero keeps valid", d, 2);
    wr(8'h68, 32'h2);
    rd(8'h68, d); chk("R8 write one clears valid", d, 0);

    auto_mode = 1'b0;
    wr(8'h60, 32'h0000_00C3);
    wr(8'h68, 32'h3);
    m_rv = 1'b1; m_rd = 32'h0BAD_0BAD;
    @(negedge clk); m_rv = 1'b0;
    rd(8'h68, d); chk("R11 resp before accept ignored", d, 1);
    m_ready = 1'b1;
    @(negedge clk); m_ready = 1'b0;
    @(negedge clk);
    m_rv = 1'b1; m_rd = 32'h1357_9BDF;
    reg_wr = 1'b1; reg_addr = 8'h68; reg_wdata = 32'h2;
    @(negedge clk);
    m_rv = 1'b0; reg_wr = 1'b0;
    rd(8'h68, d); chk("R9 completion beats clear", d, 2);
    rd(8'h64, d); chk("R9 response latched", d, 32'h1357_9BDF);

    m_rv = 1'b1; m_rd = 32'hDEAD_DEAD;
    @(negedge clk); m_rv = 1'b0;
    rd(8'h64, d); chk("R11 idle resp ignored", d, 32'h1357_9BDF);
    rd(8'h68, d); chk("R11 flags unchanged", d, 2);

    wr(8'h68, 32'h3);
    rd(8'h68, d); chk("R5 busy before abort", d, 1);
    wr(8'h08, 32'h0);
    rd(8'h68, d); chk("R10 abort clears status", d, 0);
    chk("R10 cmd_valid dropped", {31'd0, cmd_valid}, 0);
    rd(8'h08, d); chk("R2 run reads zero", d, 0);
    rd(8'h0C, d); chk("R10 presence zero", d, 0);
    wr(8'h08, 32'h1);
    rd(8'h68, d); chk("R10 no resume after reset", d, 0);
    chk("R10 cmd_valid stays low", {31'd0, cmd_valid}, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule